// File: doc/BRIEF.md
# Virtual Link Traffic Shaper

This block regulates transmit traffic for a small group of virtual links inside an end system. Each link is configured with a minimum spacing between frames, its bandwidth allocation gap, and with a largest permitted frame length. Frame descriptors (link number and length in bytes) enter through a valid/ready port. Each link holds at most one pending descriptor. A descriptor that is too long is thrown away and counted. A legal one waits in its link's slot until that link's gap timer has expired, and is then released toward the output.

Released frames from all links meet in a round-robin multiplexer that drives one output port. The multiplexer models the serialisation time of the shared wire with a busy counter. For every frame it grants, it reports the time the frame waited. If any released frame waits longer than half the smallest gap, a sticky error flag is raised together with the number of the offending link. Payload storage and line framing are handled elsewhere.

Top module: `vl_shaper`

## Requirements
- R1: After reset, outValid is 0, inReady is 1 for a link with an empty slot, jitterErr is 0 and dropCount is 0.
- R2: A descriptor with inLen greater than the link's limit (field `cfgMaxLen[l*LEN_W +: LEN_W]`) is accepted, never emitted, and increments dropCount by one. It does not restart that link's gap timer, so a legal descriptor that follows at once is emitted without waiting for a gap.
- R3: The gap of link l is US_PER_MS << e microsecond ticks, where e is the 3-bit field `cfgBagExp[3*l +: 3]`. Releases of one link are at least one gap apart, so two grants of that link are never closer than one gap minus the jitter bound.
- R4: Every legal descriptor is emitted exactly once, with its link and length unchanged, and in order within its link.
- R5: inReady is 0 for a link whose slot already holds a descriptor that has not yet been granted.
- R6: When several links are released, the multiplexer serves them in round-robin order, starting with the link after the last one granted. A frame that was already presented while outReady was low is granted first.
- R7: After a frame of L bytes is granted, outValid stays 0 for L*CYC_PER_BYTE cycles. When other frames are waiting, the next grant therefore follows L*CYC_PER_BYTE+1 cycles later.
- R8: outDelay gives the number of microsecond ticks the presented frame has waited since its release, saturating at JIT_TICKS+1.
- R9: If a released frame waits more than JIT_TICKS = US_PER_MS/2 ticks, jitterErr rises and stays at 1 until reset. jitterLink then holds that frame's link.
- R10: While outValid is 1 and outReady is 0, outValid, outLink and outLen stay stable, even when another link is released in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBagExp | input | 3*N | Gap exponent for each link, 3 bits per link |
| cfgMaxLen | input | N*LEN_W | Largest legal length for each link |
| inValid | input | 1 | Descriptor offered |
| inReady | output | 1 | Slot of the offered link is free |
| inLink | input | LINK_W | Link number of the offered descriptor |
| inLen | input | LEN_W | Frame length in bytes |
| outValid | output | 1 | A released frame is presented |
| outReady | input | 1 | Downstream accepts the frame |
| outLink | output | LINK_W | Link of the presented frame |
| outLen | output | LEN_W | Length of the presented frame |
| outDelay | output | DLY_W | Ticks the presented frame has waited |
| jitterErr | output | 1 | Sticky flag: a frame waited past the bound |
| jitterLink | output | LINK_W | Link that first broke the bound |
| dropCount | output | 16 | Number of oversized descriptors discarded |

## Verification
The hardest case to reach from the ports is a presented frame that must stay locked while a different link, one the round-robin pointer would prefer, becomes eligible. The bench reaches it by holding outReady low and choosing which link to inject so that the rotation would favour the newcomer. The bench then drives the whole round-robin sequence at once: it waits longer than every gap so that all links are eligible together, and stalls the output while descriptors arrive in a scrambled order. The jitter bound is crossed in the same way, by a deliberate stall held past half the smallest gap.

// File: rtl/vl_shaper_pkg.sv
package vl_shaper_pkg;

  // Strobes the control issues to the datapath each cycle.
  typedef struct packed {
    logic load;   // store the offered descriptor in its link slot
    logic drop;   // discard the offered descriptor and count it
    logic grant;  // the selected link leaves through the output port
  } shapeStrobe_t;

  // Gap length in microsecond ticks for a 3-bit exponent.
  function automatic int unsigned gapTicksOf(int unsigned usPerMs, logic [2:0] expo);
    return usPerMs << expo;
  endfunction

endpackage

// File: rtl/vl_shaper_datapath.sv
module vl_shaper_datapath
  import vl_shaper_pkg::*;
#(
  parameter int N         = 4,
  parameter int LEN_W     = 11,
  parameter int LINK_W    = 2,
  parameter int US_PER_MS = 1000,
  parameter int TICK_DIV  = 125,
  parameter int DLY_W     = 9,
  parameter int CNT_W     = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [3*N-1:0]      cfgBagExp,
  input  shapeStrobe_t        strobes,
  input  logic [LINK_W-1:0]   loadLink,
  input  logic [LEN_W-1:0]    loadLen,
  input  logic [N-1:0]        releaseVec,
  input  logic [LINK_W-1:0]   selLink,
  output logic [N-1:0]        slotFull,
  output logic [N-1:0]        releasedVec,
  output logic [N-1:0]        gapDone,
  output logic [N-1:0]        waitOver,
  output logic [LEN_W-1:0]    selLen,
  output logic [DLY_W-1:0]    selDelay,
  output logic [CNT_W-1:0]    dropCount
);

  localparam int JIT_TICKS = US_PER_MS / 2;
  localparam int GAP_W     = $clog2(US_PER_MS * 128 + 1);
  localparam int TICK_W    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DLY_W-1:0] WAIT_SAT = DLY_W'(JIT_TICKS + 1);
  localparam logic [DLY_W-1:0] WAIT_LIM = DLY_W'(JIT_TICKS);

  // Microsecond tick generator.
  logic [TICK_W-1:0] tickCnt;
  logic              tick;

  assign tick = (tickCnt == TICK_W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN) tickCnt <= '0;
    else       tickCnt <= tick ? '0 : tickCnt + 1'b1;
  end

  logic [N*LEN_W-1:0] lenFlat;
  logic [N*DLY_W-1:0] waitFlat;

  for (genvar gi = 0; gi < N; gi++) begin : g_link
    logic [GAP_W-1:0] gapLimit;
    logic [GAP_W-1:0] gapCnt;
    logic [DLY_W-1:0] waitCnt;
    logic [LEN_W-1:0] lenReg;
    logic             fullReg;
    logic             relReg;
    logic             doneReg;
    logic             loadHere;
    logic             grantHere;

    assign gapLimit  = GAP_W'(gapTicksOf(US_PER_MS, cfgBagExp[3*gi +: 3]));
    assign loadHere  = strobes.load  && (loadLink == LINK_W'(gi));
    assign grantHere = strobes.grant && (selLink  == LINK_W'(gi));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        gapCnt  <= '0;
        waitCnt <= '0;
        lenReg  <= '0;
        fullReg <= 1'b0;
        relReg  <= 1'b0;
        doneReg <= 1'b1;
      end else begin
        if (loadHere) begin
          fullReg <= 1'b1;
          lenReg  <= loadLen;
        end
        if (releaseVec[gi]) begin
          relReg  <= 1'b1;
          waitCnt <= '0;
          gapCnt  <= '0;
          doneReg <= 1'b0;
        end else begin
          if (tick && !doneReg) begin
            gapCnt <= gapCnt + 1'b1;
            if ((gapCnt + 1'b1) >= gapLimit) doneReg <= 1'b1;
          end
          if (tick && relReg && (waitCnt != WAIT_SAT)) waitCnt <= waitCnt + 1'b1;
        end
        if (grantHere) begin
          fullReg <= 1'b0;
          relReg  <= 1'b0;
        end
      end
    end

    assign slotFull[gi]    = fullReg;
    assign releasedVec[gi] = relReg;
    assign gapDone[gi]     = doneReg;
    assign waitOver[gi]    = relReg && (waitCnt > WAIT_LIM);
    assign lenFlat[gi*LEN_W +: LEN_W]  = lenReg;
    assign waitFlat[gi*DLY_W +: DLY_W] = waitCnt;
  end

  assign selLen   = lenFlat[selLink*LEN_W +: LEN_W];
  assign selDelay = waitFlat[selLink*DLY_W +: DLY_W];

  always_ff @(posedge clk) begin
    if (!rstN)             dropCount <= '0;
    else if (strobes.drop) dropCount <= dropCount + 1'b1;
  end

  // A descriptor is only ever written into an empty slot.
  assert_load_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |-> !slotFull[loadLink]);

  // Only frames the shaper has released may be granted.
  assert_grant_released_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.grant |-> releasedVec[selLink]);

endmodule

// File: rtl/vl_shaper_ctrl.sv
module vl_shaper_ctrl
  import vl_shaper_pkg::*;
#(
  parameter int N            = 4,
  parameter int LEN_W        = 11,
  parameter int LINK_W       = 2,
  parameter int CYC_PER_BYTE = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [LINK_W-1:0]   inLink,
  input  logic [LEN_W-1:0]    inLen,
  input  logic [N*LEN_W-1:0]  cfgMaxLen,
  input  logic [N-1:0]        slotFull,
  input  logic [N-1:0]        releasedVec,
  input  logic [N-1:0]        gapDone,
  input  logic [N-1:0]        waitOver,
  input  logic [LEN_W-1:0]    selLen,
  input  logic                outReady,
  output logic                inReady,
  output shapeStrobe_t        strobes,
  output logic [N-1:0]        releaseVec,
  output logic [LINK_W-1:0]   selLink,
  output logic                outValid,
  output logic                jitterErr,
  output logic [LINK_W-1:0]   jitterLink
);

  localparam int BUSY_W = $clog2(((1 << LEN_W) - 1) * CYC_PER_BYTE + 2);

  // Input admission.
  logic             linkOk;
  logic             accept;
  logic             oversize;
  logic [LEN_W-1:0] limitLen;

  assign linkOk   = (int'(inLink) < N);
  assign inReady  = linkOk && !slotFull[inLink];
  assign limitLen = cfgMaxLen[inLink*LEN_W +: LEN_W];
  assign accept   = inValid && inReady;
  assign oversize = inLen > limitLen;

  // Shaper release: slot occupied, not yet released, gap elapsed.
  assign releaseVec = slotFull & ~releasedVec & gapDone;

  // Round-robin pick among released links.
  logic [LINK_W-1:0] rrPtr;
  logic [LINK_W-1:0] rrLink;
  logic              anyRel;

  always_comb begin
    logic found;
    found  = 1'b0;
    rrLink = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(rrPtr) + k) % N;
      if (!found && releasedVec[idx]) begin
        found  = 1'b1;
        rrLink = LINK_W'(idx);
      end
    end
    anyRel = |releasedVec;
  end

  // Hold the presented frame while the output stalls.
  logic              lockActive;
  logic [LINK_W-1:0] lockLink;
  logic [BUSY_W-1:0] busyCnt;
  logic              grant;

  assign selLink  = lockActive ? lockLink : rrLink;
  assign outValid = (busyCnt == '0) && anyRel;
  assign grant    = outValid && outReady;

  always_comb begin
    strobes.load  = accept && !oversize;
    strobes.drop  = accept && oversize;
    strobes.grant = grant;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr      <= '0;
      lockActive <= 1'b0;
      lockLink   <= '0;
      busyCnt    <= '0;
    end else begin
      if (grant) begin
        busyCnt    <= BUSY_W'(selLen) * BUSY_W'(CYC_PER_BYTE);
        rrPtr      <= (int'(selLink) == N - 1) ? '0 : selLink + 1'b1;
        lockActive <= 1'b0;
      end else begin
        if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
        if (outValid) begin
          lockActive <= 1'b1;
          lockLink   <= selLink;
        end
      end
    end
  end

  // Jitter bound monitor: first offending link is latched.
  logic [LINK_W-1:0] overLink;

  always_comb begin
    logic seen;
    seen     = 1'b0;
    overLink = '0;
    for (int k = 0; k < N; k++) begin
      if (!seen && waitOver[k]) begin
        seen     = 1'b1;
        overLink = LINK_W'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      jitterErr  <= 1'b0;
      jitterLink <= '0;
    end else if (!jitterErr && (|waitOver)) begin
      jitterErr  <= 1'b1;
      jitterLink <= overLink;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(selLink)));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    jitterErr |=> jitterErr);

  assert_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (grant && (selLen != '0)) |=> !outValid);

endmodule

// File: rtl/vl_shaper.sv
module vl_shaper
  import vl_shaper_pkg::*;
#(
  parameter int N            = 4,
  parameter int LEN_W        = 11,
  parameter int US_PER_MS    = 1000,
  parameter int TICK_DIV     = 125,
  parameter int CYC_PER_BYTE = 10,
  parameter int LINK_W       = (N > 1) ? $clog2(N) : 1,
  parameter int DLY_W        = $clog2(US_PER_MS / 2 + 2)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [3*N-1:0]      cfgBagExp,
  input  logic [N*LEN_W-1:0]  cfgMaxLen,
  input  logic                inValid,
  output logic                inReady,
  input  logic [LINK_W-1:0]   inLink,
  input  logic [LEN_W-1:0]    inLen,
  output logic                outValid,
  input  logic                outReady,
  output logic [LINK_W-1:0]   outLink,
  output logic [LEN_W-1:0]    outLen,
  output logic [DLY_W-1:0]    outDelay,
  output logic                jitterErr,
  output logic [LINK_W-1:0]   jitterLink,
  output logic [15:0]         dropCount
);

  shapeStrobe_t      strobes;
  logic [N-1:0]      releaseVec;
  logic [N-1:0]      slotFull;
  logic [N-1:0]      releasedVec;
  logic [N-1:0]      gapDone;
  logic [N-1:0]      waitOver;
  logic [LINK_W-1:0] selLink;
  logic [LEN_W-1:0]  selLen;
  logic [DLY_W-1:0]  selDelay;

  vl_shaper_ctrl #(
    .N(N), .LEN_W(LEN_W), .LINK_W(LINK_W), .CYC_PER_BYTE(CYC_PER_BYTE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inLink(inLink), .inLen(inLen), .cfgMaxLen(cfgMaxLen),
    .slotFull(slotFull), .releasedVec(releasedVec), .gapDone(gapDone),
    .waitOver(waitOver), .selLen(selLen), .outReady(outReady),
    .inReady(inReady), .strobes(strobes), .releaseVec(releaseVec),
    .selLink(selLink), .outValid(outValid),
    .jitterErr(jitterErr), .jitterLink(jitterLink)
  );

  vl_shaper_datapath #(
    .N(N), .LEN_W(LEN_W), .LINK_W(LINK_W), .US_PER_MS(US_PER_MS),
    .TICK_DIV(TICK_DIV), .DLY_W(DLY_W), .CNT_W(16)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgBagExp(cfgBagExp), .strobes(strobes),
    .loadLink(inLink), .loadLen(inLen), .releaseVec(releaseVec),
    .selLink(selLink), .slotFull(slotFull), .releasedVec(releasedVec),
    .gapDone(gapDone), .waitOver(waitOver), .selLen(selLen),
    .selDelay(selDelay), .dropCount(dropCount)
  );

  assign outLink  = selLink;
  assign outLen   = selLen;
  assign outDelay = selDelay;

endmodule

// File: tb/vl_shaper_bench.sv
module vl_shaper_bench;

  localparam int N        = 4;
  localparam int LEN_W    = 11;
  localparam int US_MS    = 64;
  localparam int TDIV     = 2;
  localparam int CPB      = 1;
  localparam int LINK_W   = 2;
  localparam int DLY_W    = $clog2(US_MS / 2 + 2);
  localparam int JIT_CYC  = (US_MS / 2) * TDIV;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [3*N-1:0]      cfgBagExp;
  logic [N*LEN_W-1:0]  cfgMaxLen;
  logic                inValid = 1'b0;
  logic                inReady;
  logic [LINK_W-1:0]   inLink = '0;
  logic [LEN_W-1:0]    inLen = '0;
  logic                outValid;
  logic                outReady = 1'b1;
  logic [LINK_W-1:0]   outLink;
  logic [LEN_W-1:0]    outLen;
  logic [DLY_W-1:0]    outDelay;
  logic                jitterErr;
  logic [LINK_W-1:0]   jitterLink;
  logic [15:0]         dropCount;

  int bagExpB[N];
  int maxLenB[N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfgBagExp[3*i +: 3]         = 3'(bagExpB[i]);
      cfgMaxLen[i*LEN_W +: LEN_W] = LEN_W'(maxLenB[i]);
    end
  end

  vl_shaper #(
    .N(N), .LEN_W(LEN_W), .US_PER_MS(US_MS), .TICK_DIV(TDIV), .CYC_PER_BYTE(CPB)
  ) u_vl_shaper (
    .clk(clk), .rstN(rstN), .cfgBagExp(cfgBagExp), .cfgMaxLen(cfgMaxLen),
    .inValid(inValid), .inReady(inReady), .inLink(inLink), .inLen(inLen),
    .outValid(outValid), .outReady(outReady), .outLink(outLink), .outLen(outLen),
    .outDelay(outDelay), .jitterErr(jitterErr), .jitterLink(jitterLink),
    .dropCount(dropCount)
  );

  always #4 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;

  int     expQ[N][$];
  longint lastG[N];
  int     orderLog[$];
  longint grantCyc[$];

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic longint gapCycles(int l);
    return longint'(US_MS << bagExpB[l]) * TDIV;
  endfunction

  // Driver: offer one descriptor and push the expectation.
  task automatic send(int l, int len);
    @(negedge clk);
    inLink  = LINK_W'(l);
    inLen   = LEN_W'(len);
    inValid = 1'b1;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    if (len <= maxLenB[l]) expQ[l].push_back(len);
    @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  // Monitor / scoreboard.
  always begin
    @(negedge clk);
    #2;
    if (rstN && outValid && outReady) begin
      int l;
      l = int'(outLink);
      if (expQ[l].size() == 0) begin
        check(0, "R4", "unexpected frame on link", l, -1);
      end else begin
        int e;
        e = expQ[l].pop_front();
        check(int'(outLen) == e, "R4", "length", outLen, e);
      end
      if (lastG[l] >= 0)
        check((cyc - lastG[l]) >= gapCycles(l) - JIT_CYC, "R3", "same-link spacing",
              cyc - lastG[l], gapCycles(l) - JIT_CYC);
      lastG[l] = cyc;
      orderLog.push_back(l);
      grantCyc.push_back(cyc);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      bagExpB[i] = 0;
      maxLenB[i] = 20;
      lastG[i]   = -1;
    end
    bagExpB[1] = 1;
    maxLenB[3] = 10;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    // R1 reset state
    check(outValid == 1'b0, "R1", "outValid", outValid, 0);
    check(inReady == 1'b1, "R1", "inReady", inReady, 1);
    check(jitterErr == 1'b0, "R1", "jitterErr", jitterErr, 0);
    check(dropCount == 16'd0, "R1", "dropCount", dropCount, 0);

    // R3/R4: back-to-back frames on link 0, then link 1 with a doubled gap
    send(0, 10);
    send(0, 12);
    inLink = 2'd0;
    #1;
    check(inReady == 1'b0, "R5", "inReady with occupied slot", inReady, 0);
    send(0, 14);
    send(1, 7);
    send(1, 9);
    idle(1200);

    // R2: oversize on link 3 is dropped and leaves the gap timer alone
    send(3, 11);
    send(3, 8);
    begin
      bit seen3;
      seen3 = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        #2;
        if (outValid && outLink == 2'd3) seen3 = 1;
      end
      check(seen3, "R2", "legal frame after drop sent without gap wait", seen3, 1);
    end
    check(dropCount == 16'd1, "R2", "dropCount", dropCount, 1);
    idle(600);

    // R6/R7: all links eligible at once, output stalled, scrambled arrival
    begin
      int base;
      base = orderLog.size();
      outReady = 1'b0;
      send(2, 4);
      send(0, 4);
      send(3, 4);
      send(1, 4);
      @(negedge clk);
      outReady = 1'b1;
      idle(40);
      check(orderLog.size() == base + 4, "R6", "grant count", orderLog.size() - base, 4);
      if (orderLog.size() == base + 4) begin
        int expOrd[4] = '{2, 3, 0, 1};
        for (int k = 0; k < 4; k++)
          check(orderLog[base + k] == expOrd[k], "R6", "round-robin order",
                orderLog[base + k], expOrd[k]);
        for (int k = 1; k < 4; k++)
          check(grantCyc[base + k] - grantCyc[base + k - 1] == 4 * CPB + 1, "R7",
                "grant spacing after busy", grantCyc[base + k] - grantCyc[base + k - 1],
                4 * CPB + 1);
      end
    end
    idle(600);

    // R8/R10: stalled frame stays locked while a preferred link is released
    begin
      longint c0;
      longint el;
      int hLink;
      int hLen;
      int to;
      outReady = 1'b0;
      send(1, 6);
      to = 0;
      do begin
        @(negedge clk);
        #2;
        to++;
      end while (!outValid && to < 50);
      c0    = cyc;
      hLink = int'(outLink);
      hLen  = int'(outLen);
      check(hLink == 1, "R10", "presented link", hLink, 1);
      idle(5);
      send(0, 3);
      while (cyc - c0 < 20) @(negedge clk);
      #2;
      el = cyc - c0;
      check(outValid && int'(outLink) == hLink && int'(outLen) == hLen, "R10",
            "held link", outLink, hLink);
      check((int'(outDelay) >= el / 2 - 1) && (int'(outDelay) <= el / 2 + 1), "R8",
            "outDelay ticks", outDelay, el / 2);
      check(jitterErr == 1'b0, "R9", "no error below bound", jitterErr, 0);
      @(negedge clk);
      outReady = 1'b1;
      idle(30);
    end
    idle(300);

    // R9: stall past the jitter bound
    outReady = 1'b0;
    send(2, 5);
    idle(30);
    #2;
    check(jitterErr == 1'b0, "R9", "error before bound", jitterErr, 0);
    idle(80);
    #2;
    check(jitterErr == 1'b1, "R9", "error after bound", jitterErr, 1);
    check(jitterLink == 2'd2, "R9", "offending link", jitterLink, 2);
    @(negedge clk);
    outReady = 1'b1;
    idle(20);
    #2;
    check(jitterErr == 1'b1, "R9", "error stays set", jitterErr, 1);

    idle(50);
    for (int i = 0; i < N; i++)
      check(expQ[i].size() == 0, "R4", "undelivered frames", expQ[i].size(), 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule